// File: doc/BRIEF.md
# Phase-Frequency Detector with Test Overrides

This block compares a reference-divider pulse stream with a feedback-divider pulse stream and produces the two digital commands that steer a charge pump: `pump_up` when the reference leads and `pump_dn` when the feedback leads. Both inputs are resampled by a fast clock. Each 0-to-1 change seen between two successive samples counts as an edge. A four-state machine records which side arrived first. When the second side arrives, the machine holds both commands high for a programmable clearing interval and then returns to idle. Because of this, the pulse width tracks the phase error over almost a full cycle in either direction.

For bench and bring-up work, a set of register bits can mask each direction, pin the pump to one rail, or park both current sources and request a mid-supply voltage on the loop filter. The detector keeps running underneath all of these overrides. A lock flag rises after sixteen consecutive comparisons whose leading pulse is no longer than the clearing interval.

States: `ST_IDLE` (neither side pending), `ST_LEAD_UP` (reference edge seen first), `ST_LEAD_DN` (feedback edge seen first), `ST_CLEAR` (both seen, clearing interval running). Transitions: IDLE→LEAD_UP on a reference edge alone; IDLE→LEAD_DN on a feedback edge alone; IDLE→CLEAR on both edges in the same cycle; LEAD_UP→CLEAR on a feedback edge; LEAD_DN→CLEAR on a reference edge; CLEAR→IDLE when the delay count reaches `rst_dly`.

Top module: `phase_freq_detector`

## Requirements
- R1: With all controls neutral (both enables 1, no force bits), a 0-to-1 change of `ref_in` that is first sampled at rising clock edge k drives `pump_up` high after edge k+2. `fb_in` drives `pump_dn` in the same way. Falling input changes do nothing.
- R2: Once both sides have been seen, `pump_up` and `pump_dn` are both high for exactly `rst_dly`+1 cycles and then both go low. Edges sampled in the same cycle go straight to the clearing interval.
- R3: A new edge on the input that already leads is ignored until the other input arrives, so the lead pulse width and the clearing interval are unchanged.
- R4: `up_en`=0 forces `pump_up` low and `dn_en`=0 forces `pump_dn` low. The detector and the lock flag keep operating while the outputs are masked.
- R5: `force_up` alone gives `pump_up`=1 and `pump_dn`=0. `force_dn` alone gives `pump_dn`=1 and `pump_up`=0. Both together give both low. A force bit takes precedence over the enables and over the detector.
- R6: `force_mid`=1 takes precedence over every other control: both pump outputs are low and `mid_req`=1. `mid_req` is 0 whenever `force_mid` is 0. Overrides act in the same cycle.
- R7: A comparison is scored when the machine enters `ST_CLEAR`. The lead width is the number of cycles spent in LEAD_UP or LEAD_DN, or 0 for simultaneous edges. The comparison is good when this width is at most `rst_dly`+1. `locked` goes high on the 16th consecutive good comparison and goes low on the first bad one. It updates at the same edge on which the machine enters `ST_CLEAR`.
- R8: After reset, `pump_up`, `pump_dn` and `locked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Reference-divider pulse (asynchronous) |
| fb_in | input | 1 | Feedback-divider pulse (asynchronous) |
| up_en | input | 1 | Enables the up command |
| dn_en | input | 1 | Enables the down command |
| force_up | input | 1 | Pins the pump to the up direction |
| force_dn | input | 1 | Pins the pump to the down direction |
| force_mid | input | 1 | Parks both pumps and requests a mid-supply voltage |
| rst_dly | input | 3 | Clearing interval code; interval is code+1 cycles |
| pump_up | output | 1 | Charge-pump up command |
| pump_dn | output | 1 | Charge-pump down command |
| mid_req | output | 1 | Mid-supply voltage request |
| locked | output | 1 | Lock indicator |

## Verification
An input edge driven before rising edge k shows on the pump outputs after edge k+2. The other side follows d cycles later, and the clearing interval ends rst_dly+1 cycles after that. The lock flag changes at the same edge on which clearing begins. Override bits act combinationally within the cycle. The bench drives every input on the falling clock edge. At each falling edge it first samples the outputs, then indexes the expectation by the number of rising edges since the leading change, so each result is compared in the exact cycle it becomes due.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LEAD_UP = 2'd1,
        ST_LEAD_DN = 2'd2,
        ST_CLEAR   = 2'd3
    } pfd_state_e;

    localparam int unsigned DLY_W = 3;
endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_o
);
    logic [STAGES-1:0] shift_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            last_q  <= 1'b0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], din};
            last_q  <= shift_q[STAGES-1];
        end
    end

    assign rise_o = shift_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_pkg::*;
#(
    parameter int unsigned WIDTH_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_rise,
    input  logic               fb_rise,
    input  logic [DLY_W-1:0]   dly,
    output logic               up_raw,
    output logic               dn_raw,
    output logic               cmp_stb,
    output logic [WIDTH_W-1:0] lead_width
);
    localparam logic [WIDTH_W-1:0] CNT_MAX = '1;

    pfd_state_e         state_q, state_d;
    logic [WIDTH_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (ref_rise && fb_rise) begin
                    state_d = ST_CLEAR;
                end else if (ref_rise) begin
                    state_d = ST_LEAD_UP;
                    cnt_d   = WIDTH_W'(1);
                end else if (fb_rise) begin
                    state_d = ST_LEAD_DN;
                    cnt_d   = WIDTH_W'(1);
                end
            end
            ST_LEAD_UP: begin
                if (fb_rise) begin
                    state_d = ST_CLEAR;
                    cnt_d   = '0;
                end else if (cnt_q != CNT_MAX) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_LEAD_DN: begin
                if (ref_rise) begin
                    state_d = ST_CLEAR;
                    cnt_d   = '0;
                end else if (cnt_q != CNT_MAX) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_CLEAR: begin
                if (cnt_q[DLY_W-1:0] == dly) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        up_raw     = (state_q == ST_LEAD_UP) || (state_q == ST_CLEAR);
        dn_raw     = (state_q == ST_LEAD_DN) || (state_q == ST_CLEAR);
        cmp_stb    = (state_q != ST_CLEAR) && (state_d == ST_CLEAR);
        lead_width = (state_q == ST_IDLE) ? '0 : cnt_q;
    end
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock
    import pfd_pkg::*;
#(
    parameter int unsigned WIDTH_W    = 5,
    parameter int unsigned LOCK_COUNT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmp_stb,
    input  logic [WIDTH_W-1:0] lead_width,
    input  logic [DLY_W-1:0]   dly,
    output logic               locked
);
    localparam int unsigned LC_W = $clog2(LOCK_COUNT + 1);
    localparam int unsigned EW   = (WIDTH_W > DLY_W ? WIDTH_W : DLY_W) + 1;
    localparam logic [LC_W-1:0] LC_TOP = LC_W'(LOCK_COUNT);

    logic [LC_W-1:0] good_q;
    logic            good_cmp;

    assign good_cmp = EW'(lead_width) <= (EW'(dly) + EW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            good_q <= '0;
        end else if (cmp_stb) begin
            if (!good_cmp) begin
                good_q <= '0;
            end else if (good_q != LC_TOP) begin
                good_q <= good_q + 1'b1;
            end
        end
    end

    assign locked = (good_q == LC_TOP);
endmodule

// File: rtl/phase_freq_detector.sv
module phase_freq_detector
    import pfd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WIDTH_W     = 5,
    parameter int unsigned LOCK_COUNT  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic             up_en,
    input  logic             dn_en,
    input  logic             force_up,
    input  logic             force_dn,
    input  logic             force_mid,
    input  logic [DLY_W-1:0] rst_dly,
    output logic             pump_up,
    output logic             pump_dn,
    output logic             mid_req,
    output logic             locked
);
    localparam int unsigned N_IN = 2;

    logic [N_IN-1:0]    pin_vec;
    logic [N_IN-1:0]    rise_vec;
    logic               up_raw, dn_raw, cmp_stb;
    logic [WIDTH_W-1:0] lead_width;

    assign pin_vec = {fb_in, ref_in};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .din    (pin_vec[g]),
            .rise_o (rise_vec[g])
        );
    end

    pfd_core #(.WIDTH_W(WIDTH_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_rise   (rise_vec[0]),
        .fb_rise    (rise_vec[1]),
        .dly        (rst_dly),
        .up_raw     (up_raw),
        .dn_raw     (dn_raw),
        .cmp_stb    (cmp_stb),
        .lead_width (lead_width)
    );

    pfd_lock #(.WIDTH_W(WIDTH_W), .LOCK_COUNT(LOCK_COUNT)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmp_stb    (cmp_stb),
        .lead_width (lead_width),
        .dly        (rst_dly),
        .locked     (locked)
    );

    // Override priority: mid park, then rail forces, then direction masks.
    always_comb begin
        mid_req = 1'b0;
        if (force_mid) begin
            pump_up = 1'b0;
            pump_dn = 1'b0;
            mid_req = 1'b1;
        end else if (force_up || force_dn) begin
            pump_up = force_up & ~force_dn;
            pump_dn = force_dn & ~force_up;
        end else begin
            pump_up = up_raw & up_en;
            pump_dn = dn_raw & dn_en;
        end
    end
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker (
    input logic clk,
    input logic rst_n,
    input logic up_en,
    input logic dn_en,
    input logic force_up,
    input logic force_dn,
    input logic force_mid,
    input logic pump_up,
    input logic pump_dn,
    input logic mid_req
);
    logic [3:0] both_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            both_run_q <= '0;
        end else if (pump_up && pump_dn) begin
            if (both_run_q != 4'hF) both_run_q <= both_run_q + 1'b1;
        end else begin
            both_run_q <= '0;
        end
    end

    a_r6_mid_parks: assert property (@(posedge clk) disable iff (!rst_n)
        force_mid |-> (!pump_up && !pump_dn && mid_req));

    a_r6_mid_only_when_forced: assert property (@(posedge clk) disable iff (!rst_n)
        !force_mid |-> !mid_req);

    a_r5_both_forced_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (force_up && force_dn && !force_mid) |-> (!pump_up && !pump_dn));

    a_r5_force_up_rail: assert property (@(posedge clk) disable iff (!rst_n)
        (force_up && !force_dn && !force_mid) |-> (pump_up && !pump_dn));

    a_r5_force_dn_rail: assert property (@(posedge clk) disable iff (!rst_n)
        (force_dn && !force_up && !force_mid) |-> (pump_dn && !pump_up));

    a_r4_up_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_en && !force_up) |-> !pump_up);

    a_r4_dn_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!dn_en && !force_dn) |-> !pump_dn);

    a_r2_clear_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        both_run_q <= 4'd8);
endmodule

bind phase_freq_detector pfd_checker u_pfd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .up_en     (up_en),
    .dn_en     (dn_en),
    .force_up  (force_up),
    .force_dn  (force_dn),
    .force_mid (force_mid),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .mid_req   (mid_req)
);

// File: tb/test_phase_freq_detector.sv
module test_phase_freq_detector;
    localparam time CLK_P = 20ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0, fb_in = 1'b0;
    logic       up_en = 1'b1, dn_en = 1'b1;
    logic       force_up = 1'b0, force_dn = 1'b0, force_mid = 1'b0;
    logic [2:0] rst_dly = 3'd0;
    logic       pump_up, pump_dn, mid_req, locked;

    int n_cmp = 0;
    int n_bad = 0;
    int good_run = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    phase_freq_detector i_phase_freq_detector (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .up_en(up_en), .dn_en(dn_en), .force_up(force_up), .force_dn(force_dn),
        .force_mid(force_mid), .rst_dly(rst_dly),
        .pump_up(pump_up), .pump_dn(pump_dn), .mid_req(mid_req), .locked(locked)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Expected {pump_up, pump_dn} from raw detector commands and controls.
    function automatic logic [1:0] exp_pump(input logic ru, input logic rd);
        if (force_mid) return 2'b00;
        if (force_up || force_dn) return {force_up & ~force_dn, force_dn & ~force_up};
        return {ru & up_en, rd & dn_en};
    endfunction

    function automatic logic exp_lock_after(input int d, input int code);
        if (d <= code + 1) return (good_run + 1 >= 16);
        return 1'b0;
    endfunction

    // One comparison: leading side rises at step 0, lagging at step d.
    task automatic run_trial(input bit lead_ref, input int d, input int code, input bit retrig, input string req);
        logic       lock_prev;
        logic       lock_new;
        logic [1:0] e;
        logic       lead, lag;
        int         last;
        lock_prev = locked;
        lock_new  = exp_lock_after(d, code);
        rst_dly   = 3'(code);
        last      = 5 + d + code;
        for (int i = 0; i <= last; i++) begin
            @(negedge clk);
            lead = (i >= 3) && (i < 4 + d + code);
            lag  = (i >= 3 + d) && (i < 4 + d + code);
            e = lead_ref ? exp_pump(lead, lag) : exp_pump(lag, lead);
            chk(req, "pump_up", pump_up, e[1]);
            chk(req, "pump_dn", pump_dn, e[0]);
            chk("R6", "mid_req", mid_req, force_mid);
            chk(up_en && dn_en ? "R7" : "R4", "locked", locked, (i >= 3 + d) ? lock_new : lock_prev);
            if (i == 0) begin
                if (lead_ref) ref_in = 1'b1; else fb_in = 1'b1;
            end
            if (retrig && i == 1) begin
                if (lead_ref) ref_in = 1'b0; else fb_in = 1'b0;
            end
            if (retrig && i == 2) begin
                if (lead_ref) ref_in = 1'b1; else fb_in = 1'b1;
            end
            if (i == d) begin
                if (lead_ref) fb_in = 1'b1; else ref_in = 1'b1;
            end
        end
        if (d <= code + 1) good_run++; else good_run = 0;
        ref_in = 1'b0;
        fb_in  = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_ctl(input logic ue, input logic de, input logic fu, input logic fd, input logic fm);
        up_en = ue; dn_en = de; force_up = fu; force_dn = fd; force_mid = fm;
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0704));
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8", "pump_up", pump_up, 1'b0);
        chk("R8", "pump_dn", pump_dn, 1'b0);
        chk("R8", "locked", locked, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2 directed: up lead, down lead, simultaneous, longest clear
        run_trial(1'b1, 2, 3, 1'b0, "R1");
        run_trial(1'b0, 4, 1, 1'b0, "R1");
        run_trial(1'b1, 0, 0, 1'b0, "R2");
        run_trial(1'b0, 0, 7, 1'b0, "R2");
        // R3: retrigger of the leading input during the wait
        run_trial(1'b1, 6, 2, 1'b1, "R3");
        run_trial(1'b0, 5, 7, 1'b1, "R3");
        // R7: sixteen good comparisons, boundary width = code+1
        for (int k = 0; k < 16; k++) run_trial(k[0], 3, 2, 1'b0, "R7");
        chk("R7", "locked after 16 good", locked, 1'b1);
        // R7: width one above limit drops lock
        run_trial(1'b1, 4, 2, 1'b0, "R7");
        chk("R7", "locked after bad", locked, 1'b0);
        // R4: masked directions, detector keeps counting toward lock
        set_ctl(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 16; k++) run_trial(k[0], 1, 0, 1'b0, "R4");
        chk("R4", "locked while masked", locked, 1'b1);
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        run_trial(1'b0, 2, 4, 1'b0, "R4");
        // R5 / R6: forces while the detector runs
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        run_trial(1'b0, 2, 1, 1'b0, "R5");
        set_ctl(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        run_trial(1'b1, 1, 1, 1'b0, "R5");
        set_ctl(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        run_trial(1'b1, 2, 2, 1'b0, "R6");
        // R6: same-cycle effect of force_mid
        set_ctl(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        #1;
        chk("R5", "pump_dn forced", pump_dn, 1'b1);
        force_mid = 1'b1;
        #1;
        chk("R6", "pump_dn parked", pump_dn, 1'b0);
        chk("R6", "mid_req", mid_req, 1'b1);
        set_ctl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

        // Random mix
        for (int t = 0; t < 120; t++) begin
            int code, d, sel;
            code = $urandom_range(0, 7);
            d    = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 10) : $urandom_range(0, code + 1);
            sel  = $urandom_range(0, 9);
            if (sel < 6) set_ctl(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
            else set_ctl(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                         1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                         1'(sel == 9));
            run_trial(1'($urandom_range(0, 1)), d, code, 1'($urandom_range(0, 1)) && d >= 3,
                      force_mid ? "R6" : ((force_up || force_dn) ? "R5" : "R2"));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule